// File: doc/BRIEF.md
# Token-Chain Sparse Hit Readout

This block reads out a square matrix of hit-latching pixel cells during the quiet interval after detection has ended. A start pulse makes it inject a token into the first cell of the chain. The token then ripples past every cell that saw no hit and stops at the first cell that did. That cell pulls one active-low line on the column request bus and one on the row request bus. Its column's time-stamp buffer shows the stamp the cell froze when it was hit.

The block encodes the two request buses into a column and a row index and selects the stamp of that column. It builds a record from the three fields and shifts the record out serially. After the last bit it pulses a release strobe, and the token moves on to the next hit cell. When the token leaves the end of the chain, the block raises `done_o`. The output therefore carries only hit cells, and in chain order. A request bus with more than one line active raises a sticky error flag.

Top module: `tok_chain_rdout`

## Requirements
- R1: Coming out of reset, `tok_first_o`, `tok_adv_o`, `ser_o`, `rec_valid_o`, `done_o` and `err_o` are all 0.
- R2: In the idle or done state, `start_i` causes exactly one single-cycle `tok_first_o` pulse per readout.
- R3: Each record is 13 bits, sent MSB first on `ser_o` while `rec_valid_o` is high for exactly 13 consecutive cycles. The record is {column[3:0], row[3:0], stamp[4:0]}, where column k (row k) is the index of the low line `gx_n_i[k]` (`gy_n_i[k]`).
- R4: The stamp field is `ts_bus_i[5*c +: 5]`, where c is the column of the cell that holds the token.
- R5: Records come out in the order in which the token presents the hit cells, one record per hit cell.
- R6: `tok_adv_o` is a single-cycle pulse in the cycle right after the last bit of a record. It is never high while `rec_valid_o` is high, and there is exactly one pulse per record.
- R7: When `last_tok_i` is seen while waiting for a cell, `done_o` rises and stays high until the next `start_i`.
- R8: If no cell is hit, `done_o` rises with no record emitted.
- R9: A request bus with more than one low line sets `err_o`, which stays set until reset.
- R10: `start_i` is ignored while a readout is in progress: no second `tok_first_o`, and the record stream is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Readout clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a readout |
| gx_n_i | input | 16 | Column request bus, active low |
| gy_n_i | input | 16 | Row request bus, active low |
| ts_bus_i | input | 80 | Per-column 5-bit stamp buffers, column c at bits [5c+4:5c] |
| last_tok_i | input | 1 | Token has left the last cell |
| tok_first_o | output | 1 | Token injection into the first cell |
| tok_adv_o | output | 1 | Release the token from the current cell |
| ser_o | output | 1 | Serial record data |
| rec_valid_o | output | 1 | High during each record's 13 bits |
| done_o | output | 1 | Readout complete |
| err_o | output | 1 | Sticky multiple-request error |

## Verification
The bench builds the block with its defaults: a 16 by 16 matrix and 5-bit stamps. At that size the corner cells (0,0) and (15,15) and the full 4-bit address range are reachable. A behavioural chain model in the bench drives the buses and deliberately puts unrelated stamps on the columns that do not hold the token, so a wrong multiplexer selection shows up as a wrong stamp. The tests cover several hit patterns, including hits entered out of chain order, an empty matrix, a restart from the done state, a start pulse in mid-readout, and a forced second row line that triggers the sticky error.

// File: rtl/rdout_pkg.sv
package rdout_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INJ,
    ST_WAIT,
    ST_SHIFT,
    ST_REL,
    ST_DONE
  } rd_state_t;
endpackage

// File: rtl/req_encoder.sv
module req_encoder #(
  parameter int N  = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_n_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o,
  output logic          multi_o
);
  logic [N-1:0] act;

  assign act     = ~req_n_i;
  assign any_o   = |act;
  assign multi_o = |(act & (act - N'(1)));

  // lowest active line wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act[i]) idx_o = IW'(i);
    end
  end

  a_r3_idx_is_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> !req_n_i[idx_o]);
endmodule

// File: rtl/ts_mux.sv
module ts_mux #(
  parameter int COLS = 16,
  parameter int TSW  = 5,
  localparam int XW  = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic [COLS*TSW-1:0] ts_bus_i,
  input  logic [XW-1:0]       sel_i,
  output logic [TSW-1:0]      ts_o
);
  logic [TSW-1:0] lane [COLS];

  for (genvar c = 0; c < COLS; c++) begin : g_lane
    assign lane[c] = ts_bus_i[c*TSW +: TSW];
  end

  assign ts_o = lane[sel_i];
endmodule

// File: rtl/rec_shifter.sv
module rec_shifter #(
  parameter int RW  = 13,
  localparam int CW = $clog2(RW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [RW-1:0] rec_i,
  output logic          ser_o,
  output logic          busy_o,
  output logic          last_o
);
  logic [RW-1:0] sr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      busy_o <= 1'b0;
    end else if (load_i) begin
      sr_q   <= rec_i;
      cnt_q  <= '0;
      busy_o <= 1'b1;
    end else if (busy_o) begin
      sr_q <= sr_q << 1;
      if (cnt_q == CW'(RW - 1)) begin
        busy_o <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign ser_o  = busy_o & sr_q[RW-1];
  assign last_o = busy_o && (cnt_q == CW'(RW - 1));

  // R3: record runs its full length once begun
  a_r3_full_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !last_o |=> busy_o);
  a_r3_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !load_i);
endmodule

// File: rtl/tok_chain_rdout.sv
module tok_chain_rdout #(
  parameter int COLS = 16,
  parameter int ROWS = 16,
  parameter int TSW  = 5,
  localparam int XW  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int YW  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int RW  = XW + YW + TSW
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [COLS-1:0]     gx_n_i,
  input  logic [ROWS-1:0]     gy_n_i,
  input  logic [COLS*TSW-1:0] ts_bus_i,
  input  logic                last_tok_i,
  output logic                tok_first_o,
  output logic                tok_adv_o,
  output logic                ser_o,
  output logic                rec_valid_o,
  output logic                done_o,
  output logic                err_o
);
  import rdout_pkg::*;

  rd_state_t st_q, st_d;
  logic [XW-1:0]  x_idx;
  logic [YW-1:0]  y_idx;
  logic           x_any, y_any, x_multi, y_multi;
  logic [TSW-1:0] ts_sel;
  logic           hit, load, sh_last;

  req_encoder #(.N(COLS)) u_xenc (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_n_i(gx_n_i),
    .idx_o(x_idx), .any_o(x_any), .multi_o(x_multi));

  req_encoder #(.N(ROWS)) u_yenc (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_n_i(gy_n_i),
    .idx_o(y_idx), .any_o(y_any), .multi_o(y_multi));

  ts_mux #(.COLS(COLS), .TSW(TSW)) u_tsmux (
    .ts_bus_i(ts_bus_i), .sel_i(x_idx), .ts_o(ts_sel));

  assign hit  = x_any & y_any;
  assign load = (st_q == ST_WAIT) && !last_tok_i && hit;

  rec_shifter #(.RW(RW)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load),
    .rec_i({x_idx, y_idx, ts_sel}),
    .ser_o(ser_o), .busy_o(rec_valid_o), .last_o(sh_last));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_DONE: if (start_i) st_d = ST_INJ;
      ST_INJ:           st_d = ST_WAIT;
      ST_WAIT: begin
        if (last_tok_i) st_d = ST_DONE;
        else if (hit)   st_d = ST_SHIFT;
      end
      ST_SHIFT:         if (sh_last) st_d = ST_REL;
      ST_REL:           st_d = ST_WAIT;
      default:          st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      err_o <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_WAIT && !last_tok_i && (x_multi || y_multi)) err_o <= 1'b1;
    end
  end

  assign tok_first_o = (st_q == ST_INJ);
  assign tok_adv_o   = (st_q == ST_REL);
  assign done_o      = (st_q == ST_DONE);

  a_r2_first_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_first_o |=> !tok_first_o);
  a_r6_adv_after_record: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rec_valid_o) |-> tok_adv_o);
  a_r6_adv_not_in_record: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_adv_o |-> !rec_valid_o);
  a_r7_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);
  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  a_r10_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !done_o && !(st_q == ST_IDLE) |=> !tok_first_o);
endmodule

// File: tb/tok_chain_rdout_tb.sv
module tok_chain_rdout_tb;
  localparam int COLS = 16;
  localparam int ROWS = 16;
  localparam int TSW  = 5;
  localparam int NC   = COLS * ROWS;
  localparam int NSCN = 6;

  // {count[1:0], hit0, hit1, hit2}, hit = {col[3:0], row[3:0], ts[4:0]}
  localparam logic [40:0] SCN [NSCN] = '{
    {2'd2, 4'd1, 4'd5, 5'd30, 4'd4, 4'd7, 5'd31, 13'd0},
    {2'd1, 4'd0, 4'd0, 5'd0,  13'd0, 13'd0},
    {2'd1, 4'd15, 4'd15, 5'd31, 13'd0, 13'd0},
    {2'd3, 4'd7, 4'd3, 5'd21, 4'd7, 4'd2, 5'd10, 4'd0, 4'd9, 5'd5},
    {2'd3, 4'd3, 4'd12, 5'd17, 4'd12, 4'd3, 5'd8, 4'd9, 4'd9, 5'd22},
    {2'd0, 13'd0, 13'd0, 13'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [COLS-1:0] gx_n;
  logic [ROWS-1:0] gy_n;
  logic [COLS*TSW-1:0] ts_bus;
  logic last_tok;
  logic tok_first, tok_adv, ser, rec_valid, done, err;

  int checks = 0, errors = 0;

  tok_chain_rdout u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .gx_n_i(gx_n), .gy_n_i(gy_n), .ts_bus_i(ts_bus), .last_tok_i(last_tok),
    .tok_first_o(tok_first), .tok_adv_o(tok_adv), .ser_o(ser),
    .rec_valid_o(rec_valid), .done_o(done), .err_o(err));

  always #10 clk = ~clk;

  // behavioural cell chain
  logic       hitm [NC];
  logic [4:0] stm  [NC];
  int  pos = NC;
  logic active = 1'b0;
  logic fault = 1'b0;

  function automatic int next_hit(int from);
    for (int k = from; k < NC; k++) if (hitm[k]) return k;
    return NC;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= NC;
      active <= 1'b0;
    end else if (tok_first) begin
      pos    <= next_hit(0);
      active <= 1'b1;
    end else if (tok_adv) begin
      pos <= next_hit(pos + 1);
    end
  end

  always_comb begin
    gx_n = '1;
    gy_n = '1;
    for (int c = 0; c < COLS; c++) ts_bus[c*TSW +: TSW] = 5'((c * 7 + 3) & 31);
    if (active && pos < NC) begin
      gx_n[pos / ROWS] = 1'b0;
      gy_n[pos % ROWS] = 1'b0;
      if (fault) gy_n[(pos % ROWS) ^ 1] = 1'b0;
      ts_bus[(pos / ROWS)*TSW +: TSW] = stm[pos];
    end
    last_tok = active && (pos >= NC);
  end

  // output monitor
  logic [12:0] cur = '0;
  int bits = 0, ngot = 0, nadv = 0, nfirst = 0, shortrec = 0;
  logic [12:0] got [8];

  always @(negedge clk) begin
    if (rst_n) begin
      if (tok_first) nfirst++;
      if (tok_adv) nadv++;
      if (rec_valid) begin
        cur = {cur[11:0], ser};
        bits++;
        if (bits == 13) begin
          if (ngot < 8) got[ngot] = cur;
          ngot++;
          bits = 0;
        end
      end else if (bits != 0) begin
        shortrec++;
        bits = 0;
      end
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_scn(input logic [40:0] s, input logic mid_start);
    logic [12:0] exp [8];
    int nexp = 0;
    int n;
    for (int k = 0; k < NC; k++) begin hitm[k] = 1'b0; stm[k] = '0; end
    n = int'(s[40:39]);
    for (int j = 0; j < n; j++) begin
      logic [12:0] h = s[38 - 13*j -: 13];
      hitm[h[12:9]*ROWS + h[8:5]] = 1'b1;
      stm[h[12:9]*ROWS + h[8:5]]  = h[4:0];
    end
    for (int k = 0; k < NC; k++)
      if (hitm[k]) begin exp[nexp] = {4'(k / ROWS), 4'(k % ROWS), stm[k]}; nexp++; end
    ngot = 0; nadv = 0; nfirst = 0; shortrec = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (mid_start) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    for (int t = 0; t < 3000 && !done; t++) @(negedge clk);
    chk(done, "R7 done after last token", int'(done), 1);
    chk(ngot == nexp, "R5/R8 record count", ngot, nexp);
    for (int j = 0; j < nexp && j < ngot; j++)
      chk(got[j] == exp[j], "R3/R4/R5 record content", int'(got[j]), int'(exp[j]));
    chk(shortrec == 0, "R3 record length", shortrec, 0);
    chk(nadv == nexp, "R6 release pulses", nadv, nexp);
    chk(nfirst == 1, mid_start ? "R10 start ignored when busy" : "R2 single injection", nfirst, 1);
    repeat (3) @(negedge clk);
    chk(done, "R7 done holds", int'(done), 1);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NC; k++) begin hitm[k] = 1'b0; stm[k] = '0; end
    repeat (3) @(negedge clk);
    chk({tok_first, tok_adv, ser, rec_valid, done, err} == 6'b0, "R1 reset outputs",
        int'({tok_first, tok_adv, ser, rec_valid, done, err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({tok_first, tok_adv, rec_valid, done, err} == 5'b0, "R1 idle after reset",
        int'({tok_first, tok_adv, rec_valid, done, err}), 0);

    for (int i = 0; i < NSCN; i++) run_scn(SCN[i], 1'b0);

    // R8: empty matrix once more, explicit
    run_scn({2'd0, 39'd0}, 1'b0);
    chk(ngot == 0, "R8 no records on empty matrix", ngot, 0);

    // R10: start pulse during record stream
    run_scn(SCN[4], 1'b1);
    chk(err == 1'b0, "R9 no error on clean buses", int'(err), 0);

    // R9: two row lines active
    fault = 1'b1;
    run_scn({2'd1, 4'd2, 4'd4, 5'd9, 26'd0}, 1'b0);
    chk(err == 1'b1, "R9 error on multiple lines", int'(err), 1);
    fault = 1'b0;
    run_scn(SCN[0], 1'b0);
    chk(err == 1'b1, "R9 error sticky", int'(err), 1);

    rst_n = 1'b0;
    @(negedge clk);
    chk({done, err} == 2'b0, "R1/R9 reset clears", int'({done, err}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule